// File: doc/BRIEF.md
# Flash Bank Write-Status Generator

This block produces the status bits a flash bank returns on a read while an embedded program or erase runs. The command decoder pulses `cmd_start` once the write-enable rising edge that ends a command sequence has been seen. With that pulse it gives the kind of operation, the bit that will be programmed into data line 7, and whether the target is protected. For an erase, the protection flag means that every selected sector is protected. A behavioural array model answers with `array_done` when the work is finished. The block then drives the polling bit `dq7_o`, the time-limit bit `dq5_o` and the `ready_o` line, which is low while the bank is busy.

States: READ (read mode; the polling bit shows the stored bit), PROG (program running), ERASE (erase running), ESUSP (erase suspended), SPROG (program running inside an erase suspend), PWAIT (fixed busy window for a protected target) and TOUT (time limit exceeded).

Transitions:
- READ→PROG, READ→ERASE or READ→PWAIT on a command.
- PROG→READ and ERASE→READ on completion.
- ERASE→ESUSP on `suspend_req`.
- ESUSP→ERASE on `resume_req`.
- ESUSP→SPROG or ESUSP→PWAIT on a program command.
- SPROG→ESUSP on completion.
- PWAIT→READ, or PWAIT→ESUSP, when the window ends.
- PROG, ERASE or SPROG→TOUT when the cycle limit is reached.
- TOUT→READ on `reset_cmd`.

Top module: `wstat_gen`

## Requirements
- R1: After reset `ready_o`=1, `dq5_o`=0 and `dq7_o`=1, which is the erased stored bit.
- R2: A program command in read mode to an unprotected target makes `ready_o`=0 from the next cycle. From then on `dq7_o` shows the inverse of `cmd_bit`.
- R3: `array_done` during a program returns the bank to read mode in the next cycle. `ready_o` becomes 1 and `dq7_o` shows the programmed bit from then on.
- R4: During an erase, `dq7_o`=0 and `ready_o`=0. After `array_done`, `dq7_o`=1 and `ready_o`=1.
- R5: `suspend_req` during an erase gives `dq7_o`=1 and `ready_o`=1 from the next cycle. `resume_req` restores `dq7_o`=0 and `ready_o`=0. An erase command while suspended is ignored.
- R6: A program command while suspended shows the inverse of its bit on `dq7_o` with `ready_o`=0. Its `array_done` returns the bank to the suspended state.
- R7: A program command to a protected target keeps `ready_o`=0 and `dq7_o` at the inverse bit for exactly PROG_WIN cycles. The bank then returns to read mode with the stored bit unchanged.
- R8: An erase command with all sectors protected keeps `ready_o`=0 and `dq7_o`=0 for exactly ERASE_WIN cycles. The bank then returns to read mode with the stored bit unchanged.
- R9: If a program or erase spends OP_LIMIT cycles running without `array_done`, `dq5_o` becomes 1. `ready_o` stays 0 and `dq7_o` keeps the value for the running operation. Cycles spent in suspend do not count toward the limit. `array_done` in the last allowed cycle completes normally.
- R10: `reset_cmd` in the timed-out state clears `dq5_o` and returns to read mode without changing the stored bit.
- R11: A command that arrives while the bank is busy is ignored. The running operation and its bit do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | One-cycle pulse: command sequence complete |
| cmd_erase | input | 1 | 1 = erase command, 0 = program command |
| cmd_bit | input | 1 | Bit to be programmed on data line 7 |
| tgt_prot | input | 1 | Target protected (erase: all selected sectors protected) |
| suspend_req | input | 1 | Suspend the running erase |
| resume_req | input | 1 | Resume a suspended erase |
| array_done | input | 1 | Completion strobe from the array model |
| reset_cmd | input | 1 | Return-to-read command after a time-out |
| dq7_o | output | 1 | Polling bit |
| dq5_o | output | 1 | Time-limit-exceeded bit |
| ready_o | output | 1 | 1 = ready, 0 = busy |

## Verification
A table of eight commands covers several cases: programs of both bit values, normal erases, protected programs and protected erases. Comparing the busy and final polling values tells inversion apart from the true bit. It also shows whether a protected target leaves the stored bit untouched. Directed sequences then test the following:
- a suspended erase with a nested program, where the polling bit must differ between the suspended and nested-program states;
- time-outs of a program and of a suspended erase, where the second confirms that suspend cycles are not counted;
- completion landing on the final allowed cycle;
- commands issued while busy, with a bit choice that makes any wrongly accepted command visible.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
    typedef enum logic [2:0] {
        ST_READ  = 3'd0,
        ST_PROG  = 3'd1,
        ST_ERASE = 3'd2,
        ST_ESUSP = 3'd3,
        ST_SPROG = 3'd4,
        ST_PWAIT = 3'd5,
        ST_TOUT  = 3'd6
    } wsg_state_e;
endpackage

// File: rtl/wsg_timer.sv
module wsg_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          en,
    output logic [CW-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (en)  cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/wsg_ctrl.sv
module wsg_ctrl
    import wsg_pkg::*;
#(
    parameter int OP_LIMIT  = 16,
    parameter int PROG_WIN  = 5,
    parameter int ERASE_WIN = 9,
    parameter int CW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_start,
    input  logic          cmd_erase,
    input  logic          cmd_bit,
    input  logic          tgt_prot,
    input  logic          suspend_req,
    input  logic          resume_req,
    input  logic          array_done,
    input  logic          reset_cmd,
    input  logic [CW-1:0] main_cnt,
    input  logic [CW-1:0] aux_cnt,
    output wsg_state_e    st,
    output logic          dat_q,
    output logic          arr_q,
    output logic          op_erase_q,
    output logic          main_clr,
    output logic          main_en,
    output logic          aux_clr,
    output logic          aux_en
);
    localparam logic [CW-1:0] LIM_M1 = CW'(OP_LIMIT - 1);
    localparam logic [CW-1:0] PW_M1  = CW'(PROG_WIN - 1);
    localparam logic [CW-1:0] EW_M1  = CW'(ERASE_WIN - 1);

    wsg_state_e nxt;
    logic       susp_q;
    logic       main_hit, aux_hit, win_hit;

    assign main_hit = (main_cnt >= LIM_M1);
    assign aux_hit  = (aux_cnt >= LIM_M1);
    assign win_hit  = (aux_cnt >= (op_erase_q ? EW_M1 : PW_M1));

    assign main_clr = (st == ST_READ);
    assign main_en  = (st == ST_PROG) || (st == ST_ERASE);
    assign aux_clr  = !((st == ST_SPROG) || (st == ST_PWAIT));
    assign aux_en   = (st == ST_SPROG) || (st == ST_PWAIT);

    always_comb begin
        nxt = st;
        unique case (st)
            ST_READ:  if (cmd_start) nxt = tgt_prot ? ST_PWAIT : (cmd_erase ? ST_ERASE : ST_PROG);
            ST_PROG:  if (array_done) nxt = ST_READ;
                      else if (main_hit) nxt = ST_TOUT;
            ST_ERASE: if (array_done) nxt = ST_READ;
                      else if (suspend_req) nxt = ST_ESUSP;
                      else if (main_hit) nxt = ST_TOUT;
            ST_ESUSP: if (resume_req) nxt = ST_ERASE;
                      else if (cmd_start && !cmd_erase) nxt = tgt_prot ? ST_PWAIT : ST_SPROG;
            ST_SPROG: if (array_done) nxt = ST_ESUSP;
                      else if (aux_hit) nxt = ST_TOUT;
            ST_PWAIT: if (win_hit) nxt = susp_q ? ST_ESUSP : ST_READ;
            ST_TOUT:  if (reset_cmd) nxt = ST_READ;
            default:  nxt = ST_READ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_READ;
        else        st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dat_q      <= 1'b1;
            arr_q      <= 1'b1;
            op_erase_q <= 1'b0;
            susp_q     <= 1'b0;
        end else begin
            if (st == ST_READ && cmd_start) begin
                if (!cmd_erase) dat_q <= cmd_bit;
                op_erase_q <= cmd_erase;
                susp_q     <= 1'b0;
            end
            if (st == ST_ESUSP && resume_req) op_erase_q <= 1'b1;
            if (st == ST_ESUSP && !resume_req && cmd_start && !cmd_erase) begin
                dat_q      <= cmd_bit;
                op_erase_q <= 1'b0;
                susp_q     <= 1'b1;
            end
            if ((st == ST_PROG || st == ST_SPROG) && array_done) arr_q <= dat_q;
            if (st == ST_ERASE && array_done) arr_q <= 1'b1;
            if (st == ST_TOUT && reset_cmd) susp_q <= 1'b0;
        end
    end

    // R7/R8: the protected-target window holds while its count is short of the end
    assert_win_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PWAIT && aux_cnt < (op_erase_q ? EW_M1 : PW_M1)) |=> st == ST_PWAIT);
    // R9: the main counter never advances while the erase is suspended
    assert_susp_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ESUSP && $past(st) == ST_ESUSP) |-> $stable(main_cnt));
    // R11: a command while busy leaves the latched bit alone
    assert_busy_bit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROG) |=> $stable(dat_q));
endmodule

// File: rtl/wsg_outmux.sv
module wsg_outmux
    import wsg_pkg::*;
(
    input  wsg_state_e st,
    input  logic       dat_q,
    input  logic       arr_q,
    input  logic       op_erase_q,
    output logic       dq7,
    output logic       dq5,
    output logic       ready
);
    logic op_val;
    assign op_val = op_erase_q ? 1'b0 : ~dat_q;

    always_comb begin
        dq7   = arr_q;
        dq5   = 1'b0;
        ready = 1'b0;
        unique case (st)
            ST_READ:  begin dq7 = arr_q;  ready = 1'b1; end
            ST_PROG:  dq7 = ~dat_q;
            ST_SPROG: dq7 = ~dat_q;
            ST_ERASE: dq7 = 1'b0;
            ST_ESUSP: begin dq7 = 1'b1;   ready = 1'b1; end
            ST_PWAIT: dq7 = op_val;
            ST_TOUT:  begin dq7 = op_val; dq5 = 1'b1; end
            default:  begin dq7 = arr_q;  ready = 1'b1; end
        endcase
    end
endmodule

// File: rtl/wstat_gen.sv
module wstat_gen
    import wsg_pkg::*;
#(
    parameter int OP_LIMIT  = 1000000,
    parameter int PROG_WIN  = 250,
    parameter int ERASE_WIN = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_start,
    input  logic cmd_erase,
    input  logic cmd_bit,
    input  logic tgt_prot,
    input  logic suspend_req,
    input  logic resume_req,
    input  logic array_done,
    input  logic reset_cmd,
    output logic dq7_o,
    output logic dq5_o,
    output logic ready_o
);
    localparam int MAXV = (OP_LIMIT > PROG_WIN) ?
                          ((OP_LIMIT > ERASE_WIN) ? OP_LIMIT : ERASE_WIN) :
                          ((PROG_WIN > ERASE_WIN) ? PROG_WIN : ERASE_WIN);
    localparam int CW = $clog2(MAXV + 1);
    localparam logic [CW-1:0] LIM_M1 = CW'(OP_LIMIT - 1);

    wsg_state_e    st;
    logic          dat_q, arr_q, op_erase_q;
    logic          main_clr, main_en, aux_clr, aux_en;
    logic [CW-1:0] main_cnt, aux_cnt;

    wsg_timer #(.CW(CW)) u_main (.clk(clk), .rst_n(rst_n), .clr(main_clr), .en(main_en), .cnt(main_cnt));
    wsg_timer #(.CW(CW)) u_aux  (.clk(clk), .rst_n(rst_n), .clr(aux_clr),  .en(aux_en),  .cnt(aux_cnt));

    wsg_ctrl #(.OP_LIMIT(OP_LIMIT), .PROG_WIN(PROG_WIN), .ERASE_WIN(ERASE_WIN), .CW(CW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_erase(cmd_erase), .cmd_bit(cmd_bit),
        .tgt_prot(tgt_prot), .suspend_req(suspend_req), .resume_req(resume_req),
        .array_done(array_done), .reset_cmd(reset_cmd), .main_cnt(main_cnt), .aux_cnt(aux_cnt),
        .st(st), .dat_q(dat_q), .arr_q(arr_q), .op_erase_q(op_erase_q),
        .main_clr(main_clr), .main_en(main_en), .aux_clr(aux_clr), .aux_en(aux_en));

    wsg_outmux u_out (.st(st), .dat_q(dat_q), .arr_q(arr_q), .op_erase_q(op_erase_q),
                      .dq7(dq7_o), .dq5(dq5_o), .ready(ready_o));

    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READ && cmd_start) |=> !ready_o);
    assert_prog_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROG && array_done) |=> (ready_o && dq7_o == $past(dat_q)));
    assert_erase_poll_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERASE && !array_done && !suspend_req && main_cnt < LIM_M1) |=> (!dq7_o && !ready_o));
    assert_suspend_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERASE && suspend_req && !array_done) |=> (dq7_o && ready_o));
    assert_limit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROG && !array_done && main_cnt >= LIM_M1) |=> (dq5_o && !ready_o));
    assert_dq5_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dq5_o |-> !ready_o);
    assert_tout_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_TOUT && reset_cmd) |=> (!dq5_o && ready_o));
endmodule

// File: tb/sim_wstat_gen.sv
`timescale 1ns/1ps
module sim_wstat_gen;
    localparam int L  = 16;
    localparam int PW = 5;
    localparam int EW = 9;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_start = 0, cmd_erase = 0, cmd_bit = 0, tgt_prot = 0;
    logic suspend_req = 0, resume_req = 0, array_done = 0, reset_cmd = 0;
    logic dq7_o, dq5_o, ready_o;
    int   checks = 0, errors = 0;
    bit   finished = 0;

    always #2 clk = ~clk;

    wstat_gen #(.OP_LIMIT(L), .PROG_WIN(PW), .ERASE_WIN(EW)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_erase(cmd_erase), .cmd_bit(cmd_bit),
        .tgt_prot(tgt_prot), .suspend_req(suspend_req), .resume_req(resume_req),
        .array_done(array_done), .reset_cmd(reset_cmd),
        .dq7_o(dq7_o), .dq5_o(dq5_o), .ready_o(ready_o));

    // {erase, prot, bit, delay[7:0], busy_dq7, final_dq7}
    localparam logic [12:0] VEC [8] = '{
        {1'b0, 1'b0, 1'b0, 8'd3, 1'b1, 1'b0},
        {1'b0, 1'b0, 1'b1, 8'd5, 1'b0, 1'b1},
        {1'b1, 1'b0, 1'b0, 8'd6, 1'b0, 1'b1},
        {1'b0, 1'b0, 1'b0, 8'd2, 1'b1, 1'b0},
        {1'b0, 1'b1, 1'b1, 8'd0, 1'b0, 1'b0},
        {1'b1, 1'b1, 1'b0, 8'd0, 1'b0, 1'b0},
        {1'b1, 1'b0, 1'b0, 8'd4, 1'b0, 1'b1},
        {1'b0, 1'b1, 1'b0, 8'd0, 1'b1, 1'b1}
    };

    task automatic step(); @(negedge clk); endtask

    // compares {ready, dq5, dq7}
    task automatic chk(input string req, input logic [2:0] exp);
        logic [2:0] got;
        got = {ready_o, dq5_o, dq7_o};
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: {ready,dq5,dq7} actual=%b expected=%b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic issue(input logic er, input logic pr, input logic b);
        cmd_start = 1; cmd_erase = er; tgt_prot = pr; cmd_bit = b;
        step();
        cmd_start = 0; cmd_erase = 0; tgt_prot = 0; cmd_bit = 0;
    endtask

    task automatic pulse_done();
        array_done = 1; step(); array_done = 0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1;
        step();
        chk("R1 reset", 3'b101);

        // table walk: R2 R3 R4 R7 R8
        for (int i = 0; i < 8; i++) begin
            logic er, pr, b, eb, ef;
            int   d;
            {er, pr, b} = VEC[i][12:10];
            d  = int'(VEC[i][9:2]);
            eb = VEC[i][1];
            ef = VEC[i][0];
            issue(er, pr, b);
            chk(er ? (pr ? "R8 prot erase busy" : "R4 erase busy") : (pr ? "R7 prot prog busy" : "R2 prog busy"), {2'b00, eb});
            if (pr) begin
                repeat ((er ? EW : PW) - 1) step();
                chk(er ? "R8 window last cycle" : "R7 window last cycle", {2'b00, eb});
                step();
                chk(er ? "R8 back to read, bit kept" : "R7 back to read, bit kept", {2'b10, ef});
            end else begin
                repeat (d - 1) step();
                chk(er ? "R4 still erasing" : "R2 still programming", {2'b00, eb});
                pulse_done();
                chk(er ? "R4 erase done" : "R3 program done", {2'b10, ef});
            end
        end

        // R11: commands while busy are ignored (stored bit now 1)
        issue(1'b0, 1'b0, 1'b0);
        issue(1'b1, 1'b0, 1'b0);
        chk("R11 erase cmd while programming ignored", 3'b001);
        issue(1'b0, 1'b0, 1'b1);
        chk("R11 program cmd while programming ignored", 3'b001);
        pulse_done();
        chk("R11 original bit programmed", 3'b100);

        // R5 R6: suspend, nested program, resume (stored bit 0)
        issue(1'b1, 1'b0, 1'b0);
        step();
        suspend_req = 1; step(); suspend_req = 0;
        chk("R5 suspended", 3'b101);
        issue(1'b1, 1'b0, 1'b0);
        chk("R5 erase cmd in suspend ignored", 3'b101);
        issue(1'b0, 1'b0, 1'b1);
        chk("R6 program in suspend busy", 3'b000);
        pulse_done();
        chk("R6 back to suspend", 3'b101);
        resume_req = 1; step(); resume_req = 0;
        chk("R5 resumed", 3'b000);
        pulse_done();
        chk("R4 erase done after resume", 3'b101);

        // R9 R10: program time-out (stored bit 1)
        issue(1'b0, 1'b0, 1'b0);
        repeat (L - 1) step();
        chk("R9 program before limit", 3'b001);
        step();
        chk("R9 program time-out", 3'b011);
        repeat (3) step();
        chk("R9 time-out holds", 3'b011);
        reset_cmd = 1; step(); reset_cmd = 0;
        chk("R10 reset after time-out, bit kept", 3'b101);

        // R9: completion on the last allowed cycle wins
        issue(1'b0, 1'b0, 1'b0);
        repeat (L - 1) step();
        pulse_done();
        chk("R9 done on last cycle", 3'b100);

        // R9: erase time-out with suspend cycles not counted (stored bit 0)
        issue(1'b1, 1'b0, 1'b0);
        repeat (3) step();
        suspend_req = 1; step(); suspend_req = 0;
        repeat (20) step();
        chk("R5 long suspend stays ready", 3'b101);
        resume_req = 1; step(); resume_req = 0;
        repeat (L - 5) step();
        chk("R9 erase before limit", 3'b000);
        step();
        chk("R9 erase time-out", 3'b010);
        reset_cmd = 1; step(); reset_cmd = 0;
        chk("R10 reset after erase time-out", 3'b100);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule